// File: doc/BRIEF.md
# Calibrated Temperature Converter with Bank Maximum

This block turns raw 12-bit thermal-sensor readings into signed milli-degrees Celsius and reduces a group of readings (a "bank") to its hottest value. Three 32-bit fuse words give per-device constants: gain error, reference temperature and slope correction. They also give a 9-bit offset for each of five sensors. A load strobe captures and unpacks them. If the words are marked uncalibrated, built-in defaults are used instead.

The scale factor of the transfer function depends only on calibration. It is therefore computed by a sequential divider, once after each load, and cached. Reset installs the default scale factor. Samples arrive as (sensor index, raw) pairs. Each sample is converted in one cycle. Readings that convert to an implausibly high temperature are forced to zero. A start flag opens a bank and a last flag closes it. One pulse on the result valid output carries the bank maximum. Samples must follow a calibration load by at least 2·DIV_W+8 cycles.

Top module: `thermcal_bank_max`

## Requirements
- R1: After reset, and after any load whose word 0 bit 0 is 0, the defaults apply: gain error 512, every sensor offset 260, reference temperature 40, slope 0.
- R2: With word 0 bit 0 set, a load takes the fields below, and they govern samples presented 2·DIV_W+8 or more cycles after the load:
  - gain error = word1[31:22];
  - offsets of sensors 0 and 1 = word0[25:17] and word0[16:8];
  - offset of sensor 2 = word1[8:0];
  - offsets of sensors 3 and 4 = word2[31:23] and word2[22:14].
- R3: The reference temperature is word0[6:1] and the slope magnitude is word0[31:26].
- R4: The slope is negative only when word1 bit 9 and word0 bit 7 are both 1; otherwise it is positive.
- R5: The conversion is result = ref·500 − ((q·(raw − offset − 3350)) >>> 3), where q = (1627604160 / (165 + slope)) / (10000 + gain). Both divisions truncate. The product wraps to 32-bit signed.
- R6: A converted value greater than 200000 is replaced by 0 before it enters the maximum.
- R7: The bank result is the signed maximum of its converted samples, and it may be negative. A sample carrying both start and last forms a one-sample bank.
- R8: `res_valid` is high for exactly one cycle, two clock edges after the edge that accepts a sample with `smp_last`. It is low in every other cycle, including after reset.
- R9: A sample with `smp_start` discards any partial bank in progress; only samples from the latest start count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_load | input | 1 | Capture the three fuse words |
| cal_w0 | input | 32 | Fuse word 0 |
| cal_w1 | input | 32 | Fuse word 1 |
| cal_w2 | input | 32 | Fuse word 2 |
| smp_valid | input | 1 | Sample present this cycle |
| smp_start | input | 1 | First sample of a bank |
| smp_last | input | 1 | Final sample of a bank |
| smp_idx | input | IDX_W | Sensor index 0..4 |
| smp_raw | input | RAW_W | Raw sensor reading |
| res_valid | output | 1 | Bank result pulse |
| res_max | output | 32 | Signed bank maximum in milli-degrees |

## Verification
The bench targets the slope sign rule by loading words with only one of the two sign bits set, and then with both. A design that keys off a single bit would convert those samples with the wrong slope. A very low raw value exercises the implausible-reading filter, and a reading above the reference point exercises negative results. A missing clamp would report roughly 443 °C, and a maximum seeded with zero would hide a negative bank result. Restarting a bank mid-way with a cooler sample shows whether stale partial maxima leak through. A recalibration with the valid bit clear shows whether the decoder falls back to defaults or keeps the fields it was given.

// File: rtl/tcal_pkg.sv
package tcal_pkg;

    localparam int TC_NSENS   = 5;
    localparam int TC_IDX_W   = 3;
    localparam int TC_RAW_W   = 12;
    localparam int TC_OFF_W   = 9;
    localparam int TC_GAIN_W  = 10;
    localparam int TC_REF_W   = 6;
    localparam int TC_SLOPE_W = 7;

    localparam logic [31:0] TC_NUMER      = 32'd1627604160;
    localparam logic [31:0] TC_SLOPE_BASE = 32'd165;
    localparam logic [31:0] TC_GAIN_BASE  = 32'd10000;
    localparam logic [TC_GAIN_W-1:0] TC_GAIN_DEF = 10'd512;
    localparam logic [TC_OFF_W-1:0]  TC_OFF_DEF  = 9'd260;
    localparam logic [TC_REF_W-1:0]  TC_REF_DEF  = 6'd40;
    localparam logic [31:0] TC_SCALE_DEF =
        (TC_NUMER / TC_SLOPE_BASE) / (TC_GAIN_BASE + 32'(TC_GAIN_DEF));
    localparam logic signed [31:0] TC_BIAS  = 32'sd3350;
    localparam logic signed [31:0] TC_CLAMP = 32'sd200000;
    localparam logic signed [31:0] TC_MIN   = 32'sh8000_0000;

    typedef struct packed {
        logic        [TC_GAIN_W-1:0]               gain;
        logic        [TC_REF_W-1:0]                ref_t;
        logic signed [TC_SLOPE_W-1:0]              slope;
        logic        [TC_NSENS-1:0][TC_OFF_W-1:0]  offs;
    } tc_cal_t;

    typedef enum logic [1:0] {PH_IDLE, PH_DIV1, PH_DIV2} tc_phase_t;

    function automatic tc_cal_t tc_decode(input logic [31:0] w0,
                                          input logic [31:0] w1,
                                          input logic [31:0] w2);
        tc_cal_t c;
        logic signed [TC_SLOPE_W-1:0] mag;
        mag = $signed({1'b0, w0[31:26]});
        if (!w0[0]) begin
            c.gain  = TC_GAIN_DEF;
            c.ref_t = TC_REF_DEF;
            c.slope = '0;
            for (int k = 0; k < TC_NSENS; k++) c.offs[k] = TC_OFF_DEF;
        end else begin
            c.gain    = w1[31:22];
            c.ref_t   = w0[6:1];
            c.slope   = (w1[9] & w0[7]) ? -mag : mag;
            c.offs[0] = w0[25:17];
            c.offs[1] = w0[16:8];
            c.offs[2] = w1[8:0];
            c.offs[3] = w2[31:23];
            c.offs[4] = w2[22:14];
        end
        return c;
    endfunction

    function automatic logic signed [31:0] tc_max(input logic signed [31:0] a,
                                                  input logic signed [31:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tcal_seqdiv.sv
module tcal_seqdiv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, dvs_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, done_q;
    logic [W:0]    shifted, trial;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                dvs_q  <= divisor;
                cnt_q  <= CW'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done     = done_q;
    assign quotient = quo_q;
endmodule

// File: rtl/tcal_convert.sv
module tcal_convert
    import tcal_pkg::*;
(
    input  logic [31:0]          scale,
    input  logic [TC_RAW_W-1:0]  raw,
    input  logic [TC_OFF_W-1:0]  offset,
    input  logic [TC_REF_W-1:0]  ref_t,
    output logic signed [31:0]   temp_mc
);
    logic signed [31:0] diff, prod, shifted, base, result;

    always_comb begin
        diff    = $signed({{(32-TC_RAW_W){1'b0}}, raw})
                - $signed({{(32-TC_OFF_W){1'b0}}, offset}) - TC_BIAS;
        prod    = $signed(scale) * diff;
        shifted = prod >>> 3;
        base    = $signed({{(32-TC_REF_W){1'b0}}, ref_t}) * 32'sd500;
        result  = base - shifted;
        temp_mc = (result > TC_CLAMP) ? 32'sd0 : result;
    end
endmodule

// File: rtl/tcal_max_accum.sv
module tcal_max_accum
    import tcal_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_start,
    input  logic               in_last,
    input  logic signed [31:0] in_val,
    output logic signed [31:0] run_max,
    output logic               out_valid,
    output logic signed [31:0] out_max
);
    logic signed [31:0] seed, next_max;

    always_comb begin
        seed     = in_start ? TC_MIN : run_max;
        next_max = tc_max(seed, in_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_max   <= TC_MIN;
            out_valid <= 1'b0;
            out_max   <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                run_max <= next_max;
                if (in_last) begin
                    out_valid <= 1'b1;
                    out_max   <= next_max;
                end
            end
        end
    end
endmodule

// File: rtl/thermcal_bank_max.sv
module thermcal_bank_max
    import tcal_pkg::*;
#(
    parameter int DIV_W = 32,
    parameter int IDX_W = TC_IDX_W,
    parameter int RAW_W = TC_RAW_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cal_load,
    input  logic [31:0]        cal_w0,
    input  logic [31:0]        cal_w1,
    input  logic [31:0]        cal_w2,
    input  logic               smp_valid,
    input  logic               smp_start,
    input  logic               smp_last,
    input  logic [IDX_W-1:0]   smp_idx,
    input  logic [RAW_W-1:0]   smp_raw,
    output logic               res_valid,
    output logic signed [31:0] res_max
);
    tc_cal_t    cal_q;
    tc_phase_t  phase_q;
    logic       kick_q;
    logic [DIV_W-1:0] scale_q;

    logic             dv_start, dv_done, scale_wr;
    logic [DIV_W-1:0] dv_dividend, dv_divisor, dv_quo;
    logic signed [DIV_W-1:0] slope_ext;

    // calibration capture and scale-factor sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q   <= tc_decode('0, '0, '0);
            scale_q <= DIV_W'(TC_SCALE_DEF);
            phase_q <= PH_IDLE;
            kick_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: if (kick_q) begin
                    phase_q <= PH_DIV1;
                    kick_q  <= 1'b0;
                end
                PH_DIV1: if (dv_done) phase_q <= PH_DIV2;
                PH_DIV2: if (dv_done) begin
                    phase_q <= PH_IDLE;
                    scale_q <= dv_quo;
                end
                default: phase_q <= PH_IDLE;
            endcase
            if (cal_load) begin
                cal_q  <= tc_decode(cal_w0, cal_w1, cal_w2);
                kick_q <= 1'b1;
            end
        end
    end

    always_comb begin
        slope_ext   = DIV_W'(cal_q.slope);
        dv_start    = ((phase_q == PH_IDLE) && kick_q) ||
                      ((phase_q == PH_DIV1) && dv_done);
        dv_dividend = (phase_q == PH_IDLE) ? DIV_W'(TC_NUMER) : dv_quo;
        dv_divisor  = (phase_q == PH_IDLE)
                    ? DIV_W'(TC_SLOPE_BASE) + slope_ext
                    : DIV_W'(TC_GAIN_BASE) + DIV_W'(cal_q.gain);
        scale_wr    = (phase_q == PH_DIV2) && dv_done;
    end

    tcal_seqdiv #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (dv_start),
        .dividend (dv_dividend),
        .divisor  (dv_divisor),
        .done     (dv_done),
        .quotient (dv_quo)
    );

    // per-sample conversion
    logic [TC_OFF_W-1:0] off_sel;
    logic signed [31:0]  cnv_val;

    always_comb begin
        off_sel = TC_OFF_DEF;
        for (int k = 0; k < TC_NSENS; k++)
            if (smp_idx == IDX_W'(k)) off_sel = cal_q.offs[k];
    end

    tcal_convert u_cnv (
        .scale   (32'(scale_q)),
        .raw     (TC_RAW_W'(smp_raw)),
        .offset  (off_sel),
        .ref_t   (cal_q.ref_t),
        .temp_mc (cnv_val)
    );

    logic               cv_valid, cv_start, cv_last;
    logic signed [31:0] cv_val, acc_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cv_valid <= 1'b0;
            cv_start <= 1'b0;
            cv_last  <= 1'b0;
            cv_val   <= '0;
        end else begin
            cv_valid <= smp_valid;
            cv_start <= smp_start;
            cv_last  <= smp_last;
            cv_val   <= cnv_val;
        end
    end

    tcal_max_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (cv_valid),
        .in_start  (cv_start),
        .in_last   (cv_last),
        .in_val    (cv_val),
        .run_max   (acc_run),
        .out_valid (res_valid),
        .out_max   (res_max)
    );
endmodule

// File: rtl/tcal_checker.sv
module tcal_checker (
    input logic               clk,
    input logic               rst,
    input logic               smp_valid,
    input logic               smp_last,
    input logic               res_valid,
    input logic signed [31:0] res_max,
    input logic               cv_valid,
    input logic               cv_start,
    input logic signed [31:0] run_max,
    input logic               scale_wr,
    input logic [31:0]        scale_q,
    input logic               dv_start,
    input logic [31:0]        dv_divisor
);
    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_last) |=> ##1 res_valid); // R8
    AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(smp_valid && smp_last, 2)); // R8
    AST_NO_BOGUS_HIGH: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_max <= 32'sd200000)); // R6
    AST_RUN_MONOTONE: assert property (@(posedge clk) disable iff (rst)
        (cv_valid && !cv_start) |=> (run_max >= $past(run_max))); // R7
    AST_SCALE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !scale_wr |=> $stable(scale_q)); // R2
    AST_DIVISOR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        dv_start |-> (dv_divisor != 32'd0)); // R5
endmodule

bind thermcal_bank_max tcal_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .smp_last   (smp_last),
    .res_valid  (res_valid),
    .res_max    (res_max),
    .cv_valid   (cv_valid),
    .cv_start   (cv_start),
    .run_max    (acc_run),
    .scale_wr   (scale_wr),
    .scale_q    (scale_q),
    .dv_start   (dv_start),
    .dv_divisor (dv_divisor)
);

// File: tb/sim_thermcal_bank_max.sv
module sim_thermcal_bank_max;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cal_load = 1'b0;
    logic [31:0] cal_w0 = '0, cal_w1 = '0, cal_w2 = '0;
    logic        smp_valid = 1'b0, smp_start = 1'b0, smp_last = 1'b0;
    logic [2:0]  smp_idx = '0;
    logic [11:0] smp_raw = '0;
    logic        res_valid;
    logic signed [31:0] res_max;

    int checks = 0;
    int errors = 0;

    // bench model of the active calibration
    int m_gain, m_ref, m_slope;
    int m_offs [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    thermcal_bank_max u0 (
        .clk(clk), .rst(rst), .cal_load(cal_load),
        .cal_w0(cal_w0), .cal_w1(cal_w1), .cal_w2(cal_w2),
        .smp_valid(smp_valid), .smp_start(smp_start), .smp_last(smp_last),
        .smp_idx(smp_idx), .smp_raw(smp_raw),
        .res_valid(res_valid), .res_max(res_max)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int m_conv(input int idx, input int raw);
        int q, t, r;
        q = 1627604160 / (165 + m_slope);
        q = q / (10000 + m_gain);
        t = q * (raw - m_offs[idx] - 3350);
        t = t >>> 3;
        r = m_ref * 500 - t;
        if (r > 200000) r = 0;
        return r;
    endfunction

    task automatic model_defaults();
        m_gain = 512; m_ref = 40; m_slope = 0;
        foreach (m_offs[k]) m_offs[k] = 260;
    endtask

    task automatic load(input bit vld, input int gain, input int o0, input int o1,
                        input int o2, input int o3, input int o4, input int rf,
                        input int smag, input bit sbit, input bit idbit);
        cal_w0 = {smag[5:0], o0[8:0], o1[8:0], sbit, rf[5:0], vld};
        cal_w1 = {gain[9:0], 12'hA5A, idbit, o2[8:0]};
        cal_w2 = {o3[8:0], o4[8:0], 14'h1555};
        cal_load = 1'b1;
        @(negedge clk);
        cal_load = 1'b0;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic send(input bit st, input bit ls, input int idx, input int raw);
        smp_valid = 1'b1; smp_start = st; smp_last = ls;
        smp_idx = idx[2:0]; smp_raw = raw[11:0];
        @(negedge clk);
        smp_valid = 1'b0; smp_start = 1'b0; smp_last = 1'b0;
    endtask

    task automatic expect_res(input string req, input int exp);
        @(negedge clk);
        chk(req, int'(res_valid), 1);
        chk(req, res_max, exp);
    endtask

    task automatic t_reset();
        chk("R8 reset", int'(res_valid), 0);
        model_defaults();
        send(1, 1, 0, 3618);
        expect_res("R1 reset defaults", 19062);
    endtask

    task automatic t_latency();
        send(1, 1, 1, 3610);
        chk("R8 not early", int'(res_valid), 0);
        @(negedge clk);
        chk("R8 pulse", int'(res_valid), 1);
        chk("R5 zero diff", res_max, 20000);
        @(negedge clk);
        chk("R8 single pulse", int'(res_valid), 0);
    endtask

    task automatic t_calibrated();
        load(1, 300, 250, 270, 200, 310, 280, 45, 10, 1'b1, 1'b0);
        m_gain = 300; m_ref = 45; m_slope = 10;
        m_offs[0] = 250; m_offs[1] = 270; m_offs[2] = 200;
        m_offs[3] = 310; m_offs[4] = 280;
        for (int k = 0; k < 5; k++) begin
            send(1, 1, k, 3700);
            expect_res("R2 sensor offset", m_conv(k, 3700));
        end
        send(1, 1, 0, 3500);
        expect_res("R3 ref and slope", m_conv(0, 3500));
    endtask

    task automatic t_slope_sign();
        load(1, 700, 100, 120, 140, 160, 180, 30, 40, 1'b0, 1'b1);
        m_gain = 700; m_ref = 30; m_slope = 40;
        m_offs[0] = 100; m_offs[1] = 120; m_offs[2] = 140;
        m_offs[3] = 160; m_offs[4] = 180;
        send(1, 1, 3, 3900);
        expect_res("R4 id bit only", m_conv(3, 3900));
        load(1, 700, 100, 120, 140, 160, 180, 30, 40, 1'b1, 1'b1);
        m_slope = -40;
        send(1, 1, 3, 3900);
        expect_res("R4 both bits negate", m_conv(3, 3900));
        send(1, 1, 4, 3300);
        expect_res("R5 negative slope", m_conv(4, 3300));
    endtask

    task automatic t_defaults();
        load(0, 900, 11, 22, 33, 44, 55, 60, 50, 1'b1, 1'b1);
        model_defaults();
        send(1, 1, 2, 3618);
        expect_res("R1 uncalibrated load", 19062);
        send(1, 1, 4, 3700);
        expect_res("R1 default offset", m_conv(4, 3700));
    endtask

    task automatic t_clamp();
        send(1, 1, 0, 0);
        expect_res("R6 bogus clamp", 0);
        send(1, 1, 0, 4095);
        expect_res("R7 negative single", -36866);
        send(1, 0, 0, 4095);
        send(0, 1, 1, 0);
        expect_res("R6 clamp in bank", 0);
    endtask

    task automatic t_bank_max();
        int e;
        e = m_conv(0, 3700);
        if (m_conv(1, 3500) > e) e = m_conv(1, 3500);
        if (m_conv(4, 3900) > e) e = m_conv(4, 3900);
        send(1, 0, 0, 3700);
        send(0, 0, 1, 3500);
        send(0, 1, 4, 3900);
        expect_res("R7 bank max", e);
        send(1, 0, 0, 4000);
        send(0, 1, 1, 4095);
        expect_res("R7 all negative", m_conv(0, 4000));
    endtask

    task automatic t_restart();
        send(1, 0, 0, 3500);
        send(1, 1, 1, 3700);
        expect_res("R9 restart discards", m_conv(1, 3700));
        send(1, 0, 2, 3400);
        send(0, 0, 2, 3450);
        send(1, 0, 3, 3800);
        send(0, 1, 3, 3900);
        expect_res("R9 restart mid bank", m_conv(3, 3800));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_clamp();
        t_calibrated();
        t_slope_sign();
        t_defaults();
        t_bank_max();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule